// File: doc/BRIEF.md
# Bus Hold Monitor with Grant Revocation

This block sits between the masters of a shared on-chip bus and the arbiter that serves them. For each master it measures how many cycles in a row the master keeps the bus once it has been granted. It compares that number with a programmable limit. A master that holds the bus past the limit is treated as suspect, for example a hostile agent that keeps the bus locked. The monitor withdraws its grant, hides its request from the arbiter, forces its transfer type to idle and raises a one-cycle alarm.

A master that has been cut off is let back in only at fixed points in time. A free-running phase counter steps through ten states, and the master is re-admitted on the cycle after that counter reads zero. The arbiter's choice among requests and the data path stay outside the block. The monitor only gates the per-master request, grant and transfer-type signals, and it keeps a saturating count of revocations for each master.

Top module: `bus_hold_monitor`

## Requirements
- R1: During reset and after it, no master is cut off, every alarm is low, every revocation count is zero, and request, grant and transfer type pass through unchanged.
- R2: A master is in use in a cycle when its grant is high and its request or lock is high. If a master is in use for exactly as many consecutive cycles as the stored limit, it is not revoked. On the next consecutive cycle of use it is revoked: its cut-off flag is high from the following cycle.
- R3: A single cycle without use clears the run, so runs no longer than the limit, separated by such cycles, never cause a revocation.
- R4: Lock alone, with request low, counts as use.
- R5: While a master is cut off, its request toward the arbiter and its grant toward the master are 0, and its 2-bit transfer type is forced to idle (2'b00).
- R6: Each revocation raises that master's alarm for exactly one cycle, the same cycle in which its cut-off flag first goes high.
- R7: Each master has an 8-bit revocation count that increments by one at each revocation and saturates at 255.
- R8: A phase counter reads 0 in the first cycle after internal reset release and counts 0 to 9 repeatedly. A cut-off master is restored at the clock edge where the phase reads 0, and at no other edge.
- R9: The limit is taken from the threshold input on the first cycle after reset release and again at each revocation of that master. At all other times, changes on the input have no effect on the count in progress.
- R10: The masters are monitored independently. Use or revocation of one master leaves another master's outputs and count unchanged.
- R11: The asynchronous active-low reset is released through two flops, so the monitor leaves reset two clock edges after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| threshold | input | 8 | Limit on consecutive cycles of use |
| req_in | input | 2 | Per-master bus request |
| lock_in | input | 2 | Per-master lock request |
| grant_in | input | 2 | Per-master grant from the arbiter |
| trans_in | input | 4 | Per-master transfer type, 2 bits each |
| req_out | output | 2 | Requests passed to the arbiter, masked for cut-off masters |
| grant_out | output | 2 | Grants passed to the masters, masked for cut-off masters |
| trans_out | output | 4 | Transfer types to the bus, idle for cut-off masters |
| alarm | output | 2 | One-cycle pulse per revocation |
| cut_off | output | 2 | Master currently cut off |
| revoke_count | output | 16 | Saturating 8-bit revocation count per master |

## Verification
A run of use exactly as long as the limit, followed by one cycle longer, shows whether the compare is off by one. Runs at the limit separated by one idle cycle show whether a gap really clears the count. A lock-only hold and a hold by the other master show that lock counts as use and that the masters are kept apart. A limit change in the middle of a run, and a long hold with a limit of zero, show that the limit is sampled only at set points and that the count saturates. A reference model compares every output on every cycle, which also fixes the re-admission point to phase zero.

// File: rtl/bhm_pkg.sv
`timescale 1ns/1ps
package bhm_pkg;
  localparam int XFER_W = 2;
  typedef logic [XFER_W-1:0] xfer_t;
  localparam xfer_t XFER_IDLE = 2'b00;
endpackage

// File: rtl/bhm_reset_sync.sv
`timescale 1ns/1ps
module bhm_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic meta_d;
  logic sync_q;
  logic sync_d;

  always_comb begin
    meta_d = 1'b1;
    sync_d = meta_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/bhm_phase_ticker.sv
`timescale 1ns/1ps
module bhm_phase_ticker #(
  parameter int PERIOD = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase_zero
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  always_comb begin
    phase_d = (phase_q == LAST) ? '0 : phase_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_zero = (phase_q == '0);

  // R8: phase never leaves its range
  assert_phase_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST);
  // R8: a zero phase is followed by phase one
  assert_phase_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_zero |=> !phase_zero || (PERIOD == 1));
endmodule

// File: rtl/bhm_master_guard.sv
`timescale 1ns/1ps
module bhm_master_guard
  import bhm_pkg::*;
#(
  parameter int THR_W       = 8,
  parameter int CNT_W       = 8,
  parameter int DEFAULT_THR = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             phase_zero,
  input  logic [THR_W-1:0] threshold,
  input  logic             req,
  input  logic             lock,
  input  logic             grant,
  input  xfer_t            trans,
  output logic             req_o,
  output logic             grant_o,
  output xfer_t            trans_o,
  output logic             alarm,
  output logic             blocked,
  output logic [CNT_W-1:0] revokes
);
  logic [THR_W-1:0] thr_q, thr_d;
  logic [THR_W-1:0] hold_q, hold_d;
  logic             blk_q, blk_d;
  logic             alm_q, alm_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             in_use;
  logic             at_limit;

  always_comb begin
    in_use   = armed && !blk_q && grant && (req || lock);
    at_limit = in_use && (hold_q == thr_q);
    thr_d    = (!armed || at_limit) ? threshold : thr_q;
    hold_d   = (!in_use || at_limit) ? '0 : hold_q + THR_W'(1);
    blk_d    = blk_q;
    if (at_limit)                blk_d = 1'b1;
    else if (blk_q && phase_zero) blk_d = 1'b0;
    alm_d    = at_limit;
    cnt_d    = (at_limit && cnt_q != '1) ? cnt_q + CNT_W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= THR_W'(DEFAULT_THR);
      hold_q <= '0;
      blk_q  <= 1'b0;
      alm_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      thr_q  <= thr_d;
      hold_q <= hold_d;
      blk_q  <= blk_d;
      alm_q  <= alm_d;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    req_o   = req   && !blk_q;
    grant_o = grant && !blk_q;
    trans_o = blk_q ? XFER_IDLE : trans;
  end

  assign alarm   = alm_q;
  assign blocked = blk_q;
  assign revokes = cnt_q;

  // R2: a run never exceeds the stored limit
  assert_hold_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= thr_q);
  // R6: alarm lasts one cycle
  assert_alarm_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alm_q |=> !alm_q);
  // R6: cut-off starts together with the alarm
  assert_block_alarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_q) |-> alm_q);
  // R8: restore only after a zero phase
  assert_restore_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_q) |-> $past(phase_zero));
  // R7: count never decreases
  assert_count_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q >= $past(cnt_q));
  // R5: a cut-off master presents an idle transfer
  assert_idle_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q |-> (trans_o == XFER_IDLE) && !grant_o);
endmodule

// File: rtl/bus_hold_monitor.sv
`timescale 1ns/1ps
module bus_hold_monitor
  import bhm_pkg::*;
#(
  parameter int NUM_MASTERS = 2,
  parameter int THR_W       = 8,
  parameter int CNT_W       = 8,
  parameter int PERIOD      = 10,
  parameter int DEFAULT_THR = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [THR_W-1:0]              threshold,
  input  logic [NUM_MASTERS-1:0]        req_in,
  input  logic [NUM_MASTERS-1:0]        lock_in,
  input  logic [NUM_MASTERS-1:0]        grant_in,
  input  logic [XFER_W*NUM_MASTERS-1:0] trans_in,
  output logic [NUM_MASTERS-1:0]        req_out,
  output logic [NUM_MASTERS-1:0]        grant_out,
  output logic [XFER_W*NUM_MASTERS-1:0] trans_out,
  output logic [NUM_MASTERS-1:0]        alarm,
  output logic [NUM_MASTERS-1:0]        cut_off,
  output logic [CNT_W*NUM_MASTERS-1:0]  revoke_count
);
  logic rst_sync_n;
  logic phase_zero;
  logic armed_q, armed_d;

  bhm_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bhm_phase_ticker #(.PERIOD(PERIOD)) u_phase (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .phase_zero (phase_zero)
  );

  always_comb armed_d = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed_q <= 1'b0;
    else             armed_q <= armed_d;
  end

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
    bhm_master_guard #(
      .THR_W       (THR_W),
      .CNT_W       (CNT_W),
      .DEFAULT_THR (DEFAULT_THR)
    ) u_guard (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .armed      (armed_q),
      .phase_zero (phase_zero),
      .threshold  (threshold),
      .req        (req_in[m]),
      .lock       (lock_in[m]),
      .grant      (grant_in[m]),
      .trans      (trans_in[m*XFER_W +: XFER_W]),
      .req_o      (req_out[m]),
      .grant_o    (grant_out[m]),
      .trans_o    (trans_out[m*XFER_W +: XFER_W]),
      .alarm      (alarm[m]),
      .blocked    (cut_off[m]),
      .revokes    (revoke_count[m*CNT_W +: CNT_W])
    );
  end

  // R10: revocations are per master, so two alarms need two cut-offs
  assert_alarm_cut_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(alarm & ~cut_off) == 0);
endmodule

// File: tb/bus_hold_monitor_test.sv
`timescale 1ns/1ps
module bus_hold_monitor_test;
  localparam int NM = 2;

  logic       clk;
  logic       rst_n;
  logic [7:0] threshold;
  logic [1:0] req_in, lock_in, grant_in;
  logic [3:0] trans_in;
  logic [1:0] req_out, grant_out, alarm, cut_off;
  logic [3:0] trans_out;
  logic [15:0] revoke_count;

  int n_checks = 0;
  int n_fail   = 0;

  bus_hold_monitor uut (
    .clk(clk), .rst_n(rst_n), .threshold(threshold),
    .req_in(req_in), .lock_in(lock_in), .grant_in(grant_in),
    .trans_in(trans_in), .req_out(req_out), .grant_out(grant_out),
    .trans_out(trans_out), .alarm(alarm), .cut_off(cut_off),
    .revoke_count(revoke_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference
  int  m_hold [NM];
  int  m_thr  [NM];
  int  m_cnt  [NM];
  bit  m_blk  [NM];
  bit  m_alm  [NM];
  int  m_phase;
  bit  m_armed, m_rs1, m_rs2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NM; i++) begin
        m_hold[i] = 0; m_thr[i] = 8; m_cnt[i] = 0; m_blk[i] = 0; m_alm[i] = 0;
      end
      m_phase = 0; m_armed = 0; m_rs1 = 0; m_rs2 = 0;
    end else begin
      if (m_rs2) begin
        for (int i = 0; i < NM; i++) begin
          bit use_c, lim;
          use_c = m_armed && !m_blk[i] && grant_in[i] && (req_in[i] || lock_in[i]);
          lim   = use_c && (m_hold[i] == m_thr[i]);
          if (!m_armed || lim) m_thr[i] = threshold;
          if (!use_c || lim) m_hold[i] = 0; else m_hold[i] = m_hold[i] + 1;
          if (lim) m_blk[i] = 1;
          else if (m_blk[i] && m_phase == 0) m_blk[i] = 0;
          m_alm[i] = lim;
          if (lim && m_cnt[i] < 255) m_cnt[i] = m_cnt[i] + 1;
        end
        m_phase = (m_phase == 9) ? 0 : m_phase + 1;
        m_armed = 1;
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    for (int i = 0; i < NM; i++) begin
      int ereq, egnt, etr, cnt_act;
      ereq = (req_in[i] && !m_blk[i]) ? 1 : 0;
      egnt = (grant_in[i] && !m_blk[i]) ? 1 : 0;
      etr  = m_blk[i] ? 0 : int'(trans_in[i*2 +: 2]);
      cnt_act = int'(revoke_count[i*8 +: 8]);
      check(req_out[i] == ereq, "R5", "req_out", int'(req_out[i]), ereq);
      check(grant_out[i] == egnt, "R5", "grant_out", int'(grant_out[i]), egnt);
      check(int'(trans_out[i*2 +: 2]) == etr, "R5", "trans_out", int'(trans_out[i*2 +: 2]), etr);
      check(alarm[i] == m_alm[i], "R6", "alarm", int'(alarm[i]), int'(m_alm[i]));
      check(cut_off[i] == m_blk[i], "R8", "cut_off", int'(cut_off[i]), int'(m_blk[i]));
      check(cnt_act == m_cnt[i], "R7", "revoke_count", cnt_act, m_cnt[i]);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      #1 compare_all();
    end
  endtask

  function automatic int cnt_of(input int i);
    return int'(revoke_count[i*8 +: 8]);
  endfunction

  initial begin
    #(200000 * 8);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; threshold = 8'd8;
    req_in = '0; lock_in = '0; grant_in = '0; trans_in = 4'b1010;
    #1 compare_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(1);
    // R11: still held in reset after one edge
    check(cut_off == 2'b00 && alarm == 2'b00, "R11", "sync release", int'(alarm), 0);
    tick(3);
    // R1: reset state
    check(revoke_count == 16'd0, "R1", "counts after reset", int'(revoke_count), 0);
    check(cut_off == 2'b00, "R1", "cut_off after reset", int'(cut_off), 0);
    check(trans_out == trans_in, "R1", "pass-through", int'(trans_out), int'(trans_in));

    // R2: run of exactly the limit is tolerated
    grant_in = 2'b01; req_in = 2'b01; trans_in = 4'b0010;
    tick(8);
    req_in = 2'b00; grant_in = 2'b00;
    tick(2);
    check(cnt_of(0) == 0, "R2", "no revoke at limit", cnt_of(0), 0);
    // R2: one cycle more revokes
    grant_in = 2'b01; req_in = 2'b01; trans_in = 4'b0011;
    tick(9);
    req_in = 2'b00; grant_in = 2'b00;
    tick(1);
    check(cut_off[0] == 1'b1, "R2", "cut off after overrun", int'(cut_off[0]), 1);
    check(cnt_of(0) == 1, "R2", "revoke count", cnt_of(0), 1);
    tick(12);
    check(cut_off[0] == 1'b0, "R8", "restored", int'(cut_off[0]), 0);

    // R3: runs at the limit separated by one idle cycle
    grant_in = 2'b01;
    for (int k = 0; k < 5; k++) begin
      req_in = 2'b01; tick(8);
      req_in = 2'b00; tick(1);
    end
    grant_in = 2'b00;
    tick(1);
    check(cnt_of(0) == 1, "R3", "gaps clear run", cnt_of(0), 1);

    // R4: lock alone holds the bus
    grant_in = 2'b01; lock_in = 2'b01;
    tick(10);
    lock_in = 2'b00; grant_in = 2'b00;
    tick(1);
    check(cnt_of(0) == 2, "R4", "lock-only revoke", cnt_of(0), 2);
    tick(12);

    // R9: mid-run threshold change is ignored
    grant_in = 2'b01; req_in = 2'b01;
    tick(3);
    threshold = 8'd20;
    tick(6);
    req_in = 2'b00; grant_in = 2'b00;
    tick(1);
    check(cnt_of(0) == 3, "R9", "old limit used", cnt_of(0), 3);
    tick(12);
    // R9: new limit of 20 was taken at revocation
    grant_in = 2'b01; req_in = 2'b01;
    tick(15);
    req_in = 2'b00; grant_in = 2'b00;
    tick(2);
    check(cnt_of(0) == 3, "R9", "new limit loaded", cnt_of(0), 3);

    // R7: saturation with a zero limit
    threshold = 8'd0;
    grant_in = 2'b01; req_in = 2'b01; trans_in = 4'b0110;
    tick(3000);
    req_in = 2'b00; grant_in = 2'b00;
    tick(12);
    check(cnt_of(0) == 255, "R7", "saturated count", cnt_of(0), 255);
    // R10: other master untouched
    check(cnt_of(1) == 0, "R10", "master1 count", cnt_of(1), 0);

    // R10: master1 uses its own limit taken after reset (8)
    threshold = 8'd8;
    grant_in = 2'b10; req_in = 2'b10; trans_in = 4'b1100;
    tick(9);
    tick(1);
    check(cut_off == 2'b10, "R10", "only master1 cut", int'(cut_off), 2);
    check(cnt_of(1) == 1, "R10", "master1 count", cnt_of(1), 1);
    check(cnt_of(0) == 255, "R10", "master0 count kept", cnt_of(0), 255);
    // R5: masked while cut off
    if (cut_off[1]) begin
      check(req_out[1] == 1'b0, "R5", "req masked", int'(req_out[1]), 0);
      check(trans_out[3:2] == 2'b00, "R5", "trans idle", int'(trans_out[3:2]), 0);
    end
    req_in = 2'b00; grant_in = 2'b00;
    tick(12);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule